// File: doc/BRIEF.md
# Race-PUF Evaluation Sequencer

This block runs one evaluation of a delay-race circuit. The race circuit has several lanes and compares the arrival order of a single rising edge on every pair of lanes. The sequencer holds the challenge that configures the lanes. It launches the rising edge onto all lanes at the same time. It then captures the pairwise order bits that the race logic reports into a response register. A host raises `init_i` to request an evaluation, watches `busy_o`, and reads `resp_o` once busy has fallen.

The controller is a four-state Moore machine with one-hot state flops. Its decoded outputs form a control word with four fields: stimulus pulse, busy, challenge-register enable and response-capture enable.

- While idle, the challenge register follows the challenge input.
- The first busy cycle lets the lanes settle with the pulse low.
- The second busy cycle drives the pulse high and enables response capture.
- The third busy cycle drops the pulse and waits for the request to be withdrawn, so that one held request never starts a second evaluation.

Top module: `race_eval_seq`

## Requirements
- R1: While `rst_ni` is low, `busy_o`, `pulse_o`, `resp_o` and `chal_o` are all zero.
- R2: While `busy_o` is low, every rising clock edge loads `chal_i` into the challenge register, so `chal_o` shows the value `chal_i` had at the previous edge.
- R3: `init_i` high at an edge while idle makes `busy_o` high and keeps `pulse_o` low after that edge. `chal_o` then holds the challenge sampled at that edge.
- R4: Each evaluation drives `pulse_o` high for exactly one cycle. That cycle is the second busy cycle, and `pulse_o` is low in the cycle before it.
- R5: At the edge that ends the pulse cycle, `resp_o` loads `order_i`, with bit k of `resp_o` taken from bit k of `order_i`.
- R6: `resp_o` changes at no other edge. Values on `order_i` outside the pulse cycle have no effect, and the old response stays visible until the next capture.
- R7: From the third busy cycle on, `busy_o` stays high for as long as `init_i` stays high. `busy_o` falls at the first edge that samples `init_i` low.
- R8: The level of `init_i` during the first two busy cycles does not alter the sequence: the pulse and the capture still follow.
- R9: Changes on `chal_i` while `busy_o` is high do not reach `chal_o`. A new evaluation starts at the first idle edge that samples `init_i` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Evaluation request, level sensitive |
| chal_i | input | CHAL_W | Challenge, one select field per race stage |
| order_i | input | ORDER_W | Pairwise order bits from the race logic |
| busy_o | output | 1 | High from request acceptance until return to idle |
| pulse_o | output | 1 | Stimulus edge, forked to all race lanes |
| chal_o | output | CHAL_W | Registered challenge driving the race stages |
| resp_o | output | ORDER_W | Captured order bits |

## Verification
A behavioural race model in the bench returns order bits computed from the registered challenge while the pulse is high, and a fixed junk pattern at all other times. A wrong capture cycle therefore shows up as the junk value in the response. Evaluations are run with several challenges and with four shapes of `init_i`:
- a request held for exactly three cycles;
- a request held several cycles longer, which tells the hold in the last state apart from a premature return;
- a request that drops and rises again inside the busy window, which tells level-insensitive sequencing apart from re-triggering;
- back-to-back requests, which test the earliest possible restart.

The challenge input is inverted during every busy window to show the register is frozen.

// File: rtl/race_eval_pkg.sv
package race_eval_pkg;

  localparam int unsigned NUM_ST  = 4;
  localparam int unsigned ST_IDLE = 0;
  localparam int unsigned ST_ARM  = 1;
  localparam int unsigned ST_FIRE = 2;
  localparam int unsigned ST_DONE = 3;

  localparam logic [NUM_ST-1:0] ST_RESET = NUM_ST'(1) << ST_IDLE;

  // Moore control word, field order follows the drive sequence
  typedef struct packed {
    logic pulse;
    logic busy;
    logic chal_en;
    logic resp_en;
  } ctl_t;

endpackage

// File: rtl/race_eval_reg.sv
module race_eval_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (en_i) q <= d_i;
  end

  assign q_o = q;

endmodule

// File: rtl/race_eval_fsm.sv
module race_eval_fsm
  import race_eval_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  output ctl_t ctl_o
);

  logic [NUM_ST-1:0] st_q, st_d;

  // one-hot next state; idle->arm on init, arm->fire->done, done holds on init
  always_comb begin
    st_d          = '0;
    st_d[ST_IDLE] = (st_q[ST_IDLE] | st_q[ST_DONE]) & ~init_i;
    st_d[ST_ARM]  = st_q[ST_IDLE] & init_i;
    st_d[ST_FIRE] = st_q[ST_ARM];
    st_d[ST_DONE] = st_q[ST_FIRE] | (st_q[ST_DONE] & init_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_RESET;
    else         st_q <= st_d;
  end

  // outputs come straight off state flops: pulse has no decode glitch
  always_comb begin
    ctl_o.pulse   = st_q[ST_FIRE];
    ctl_o.busy    = st_q[ST_ARM] | st_q[ST_FIRE] | st_q[ST_DONE];
    ctl_o.chal_en = st_q[ST_IDLE];
    ctl_o.resp_en = st_q[ST_FIRE];
  end

endmodule

// File: rtl/race_eval_seq.sv
module race_eval_seq
  import race_eval_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned SEL_W      = 5,
  parameter int unsigned NUM_LANES  = 4,
  parameter int unsigned CHAL_W     = NUM_STAGES * SEL_W,
  parameter int unsigned ORDER_W    = NUM_LANES * (NUM_LANES - 1) / 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               init_i,
  input  logic [CHAL_W-1:0]  chal_i,
  input  logic [ORDER_W-1:0] order_i,
  output logic               busy_o,
  output logic               pulse_o,
  output logic [CHAL_W-1:0]  chal_o,
  output logic [ORDER_W-1:0] resp_o
);

  ctl_t ctl;

  race_eval_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (init_i),
    .ctl_o  (ctl)
  );

  race_eval_reg #(.W(CHAL_W)) u_chal (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctl.chal_en),
    .d_i    (chal_i),
    .q_o    (chal_o)
  );

  race_eval_reg #(.W(ORDER_W)) u_resp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctl.resp_en),
    .d_i    (order_i),
    .q_o    (resp_o)
  );

  assign busy_o  = ctl.busy;
  assign pulse_o = ctl.pulse;

endmodule

// File: rtl/race_eval_seq_chk.sv
module race_eval_seq_chk #(
  parameter int unsigned CHAL_W  = 20,
  parameter int unsigned ORDER_W = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               init_i,
  input logic [ORDER_W-1:0] order_i,
  input logic               busy_o,
  input logic               pulse_o,
  input logic [CHAL_W-1:0]  chal_o,
  input logic [ORDER_W-1:0] resp_o
);

  a_r3_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && init_i) |=> (busy_o && !pulse_o));

  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

  a_r4_pulse_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> $past(busy_o));

  a_r5_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> (resp_o == $past(order_i)));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_o |=> $stable(resp_o));

  a_r8_fire_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !pulse_o && !$past(busy_o)) |=> pulse_o);

  a_r9_chal_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(chal_o));

endmodule

bind race_eval_seq race_eval_seq_chk #(
  .CHAL_W  (CHAL_W),
  .ORDER_W (ORDER_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .init_i  (init_i),
  .order_i (order_i),
  .busy_o  (busy_o),
  .pulse_o (pulse_o),
  .chal_o  (chal_o),
  .resp_o  (resp_o)
);

// File: tb/sim_race_eval_seq.sv
module sim_race_eval_seq;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 20;
  localparam int OW = 6;
  localparam logic [OW-1:0] JUNK = 6'h2A;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          init_i;
  logic [CW-1:0] chal_i;
  logic [OW-1:0] order_i;
  logic          busy_o, pulse_o;
  logic [CW-1:0] chal_o;
  logic [OW-1:0] resp_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [OW-1:0] last_resp;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  race_eval_seq u0 (
    .clk_i, .rst_ni, .init_i, .chal_i, .order_i,
    .busy_o, .pulse_o, .chal_o, .resp_o
  );

  function automatic logic [OW-1:0] race_mix(logic [CW-1:0] c);
    return c[5:0] ^ {c[11:6]} ^ {c[17:12]} ^ {4'b0, c[19:18]} ^ 6'h11;
  endfunction

  // behavioural race: order bits valid only while the edge is launched
  always_comb order_i = pulse_o ? race_mix(chal_o) : JUNK;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; init_i = 1'b0; chal_i = 20'h5A5A5;
    cyc(); cyc();
    chk("R1 busy", busy_o, 0);
    chk("R1 pulse", pulse_o, 0);
    chk("R1 resp", resp_o, 0);
    chk("R1 chal", chal_o, 0);
    rst_ni = 1'b1;
    last_resp = '0;
  endtask

  task automatic t_idle_track();
    chal_i = 20'h12345; cyc();
    chk("R2 track a", chal_o, 20'h12345);
    chal_i = 20'hFEDCB; cyc();
    chk("R2 track b", chal_o, 20'hFEDCB);
    chk("R2 idle", busy_o, 0);
  endtask

  // mode 0: init held 3 cycles; mode 1: toggled inside busy window
  task automatic t_eval(logic [CW-1:0] c, int extra_hold, int mode);
    chal_i = c; init_i = 1'b1;
    cyc();
    chk("R3 busy", busy_o, 1);
    chk("R3 no pulse", pulse_o, 0);
    chk("R3 chal", chal_o, c);
    chk("R6 old resp", resp_o, last_resp);
    chal_i = ~c;
    if (mode == 1) init_i = 1'b0;
    cyc();
    chk("R4 pulse", pulse_o, 1);
    chk("R8 busy", busy_o, 1);
    chk("R9 frozen", chal_o, c);
    chk("R6 old resp", resp_o, last_resp);
    if (mode == 1) init_i = 1'b1;
    cyc();
    chk("R4 pulse low", pulse_o, 0);
    chk("R5 resp", resp_o, race_mix(c));
    chk("R9 frozen", chal_o, c);
    last_resp = race_mix(c);
    for (int i = 0; i < extra_hold; i++) begin
      cyc();
      chk("R7 held busy", busy_o, 1);
      chk("R4 no pulse", pulse_o, 0);
    end
    init_i = 1'b0;
    cyc();
    chk("R7 idle", busy_o, 0);
    chk("R6 resp kept", resp_o, last_resp);
  endtask

  task automatic t_resp_hold();
    for (int i = 0; i < 4; i++) begin
      chal_i = 20'(i * 20'h3_1337);
      cyc();
      chk("R6 idle hold", resp_o, last_resp);
      chk("R2 idle load", chal_o, 20'(i * 20'h3_1337));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_fail++; n_chk++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_idle_track();
    t_eval(20'hABCDE, 0, 0);
    t_resp_hold();
    t_eval(20'h0F0F1, 4, 0);
    t_eval(20'h33CC3, 0, 1);   // R8 toggled init
    t_eval(20'h80001, 1, 0);   // R9 back-to-back start
    t_eval(20'h7FFFE, 0, 0);
    t_resp_hold();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule